// File: doc/BRIEF.md
# Block-Write Register Slave

This block is the slave end of a two-wire serial link running at standard-mode rates (100 kbit/s or slower). It gives a host access to a bank of 21 byte-wide configuration registers. The block samples SCL and SDA with its own fast clock. It pulls SDA low through an open-drain enable. The whole register bank is presented as one parallel bus for the logic that consumes the configuration.

Writes always use block framing. After the write address the host sends two header bytes, a command code and a byte count. Both are acknowledged and then thrown away. Every data byte after them lands in the next register, starting at register 0, until the host issues STOP. Reads return a length byte first, taken from register 8, and then registers 0, 1, 2 and so on for as long as the host keeps acknowledging.

Some registers get special handling. Two register pairs take effect only as a unit. One register holds a fixed identity code. Three registers take writes without effect.

Top module: `blkwr_reg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). For any other address it leaves SDA released in the acknowledge slot and ignores the bus until the next START.
- R2: On a write, the two bytes that follow the address are acknowledged and discarded. The first data byte after them goes to register 0.
- R3: Data bytes of a write load registers in ascending order, and each byte is acknowledged. A STOP after any acknowledged byte keeps every completed byte of that transaction.
- R4: Write data bytes addressed past register 20 are acknowledged and change no register.
- R5: A read returns register 8 first and then registers 0 upward, one byte per host acknowledge. After a host NACK the slave releases SDA.
- R6: After reset, register 8 reads 0x08, registers 1 to 5 read 0xFF and all other registers except 7 read 0x00.
- R7: Registers 11/12 and registers 13/14 form pairs. A pair is updated only when both of its bytes arrive in one transaction, and then both update together when the second byte's acknowledge completes. Otherwise neither byte changes.
- R8: Register 7 is read-only. Bits [7:5] hold the vendor code 001 and bits [4:0] hold the revision parameter.
- R9: Writes to registers 6, 19 and 20 are acknowledged but have no effect. These registers always read 0x00.
- R10: A repeated START aborts a partly received byte. That byte is not stored, any half-written pair is discarded, and a new address phase begins.
- R11: The slave drives SDA only in the acknowledge slots of bytes it accepts and in the data bits of a read. STOP returns it to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| bank_o | output | NREG*8 | Register bank; register k occupies bits [8k+7:8k] |

## Verification
The bench builds the block with its default geometry of 21 registers, device address 0x69 (7-bit) and two synchronizer stages. It overrides the revision parameter to 0x0B, so register 7 reads 0x2B and a stray write to it would show up clearly. With the default bank size, one write of 25 data bytes runs past the top of the bank. The same write sets the read length to 21, so a single read covers every register, including the inert and read-only ones. Write lengths of 12 to 15 bytes end a transaction on each side of both register pairs.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

    typedef logic [7:0] byte_t;

    localparam int POS_W   = 8;   // byte position / read pointer width
    localparam int NPAIRS  = 2;
    localparam int ID_REG  = 7;
    localparam int CNT_REG = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic             en;
        logic [POS_W-1:0] idx;
        byte_t            data;
    } wr_req_t;

    // low register index of pair p; its partner sits at +1
    function automatic int pair_base(int p);
        return (p == 0) ? 11 : 13;
    endfunction

    function automatic logic is_inert(int i);
        return (i == 6) || (i == 19) || (i == 20);
    endfunction

    function automatic logic in_pair(int i);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < NPAIRS; p++)
            if (i == pair_base(p) || i == pair_base(p) + 1) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic plain_wr(int i);
        return (i != ID_REG) && !is_inert(i) && !in_pair(i);
    endfunction

    function automatic byte_t reset_val(int i, byte_t cnt_rst, byte_t id_byte);
        if (i == CNT_REG)          return cnt_rst;
        else if (i == ID_REG)      return id_byte;
        else if (i >= 1 && i <= 5) return 8'hFF;
        else                       return 8'h00;
    endfunction

endpackage

// File: rtl/blkwr_line_sync.sv
module blkwr_line_sync
    import blkwr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int NLINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] & ~prev[1];
        ev.scl_fall = ~synced[1] & prev[1];
        ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/blkwr_engine.sv
module blkwr_engine
    import blkwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  byte_t            cnt_byte,
    input  byte_t            rd_data,
    output logic [POS_W-1:0] rd_ptr,
    output wr_req_t          wr,
    output logic             txn_end,
    output logic             sda_oe
);

    localparam logic [POS_W-1:0] HDR_BYTES = POS_W'(2);
    localparam logic [POS_W-1:0] POS_MAX   = '1;

    eng_state_e       state;
    logic [3:0]       bitcnt;
    byte_t            shreg;
    byte_t            tx;
    logic [POS_W-1:0] pos;
    logic             is_rd;
    logic             host_ack;

    assign txn_end = ev.start | ev.stop;

    always_comb begin
        wr.en   = (state == ST_WR_ACK) && ev.scl_fall && !txn_end && (pos >= HDR_BYTES);
        wr.idx  = pos - HDR_BYTES;
        wr.data = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            tx       <= '0;
            pos      <= '0;
            rd_ptr   <= '0;
            is_rd    <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (ev.scl_fall && bitcnt == 4'd8) begin
                        if (state == ST_WR) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                        end else if (shreg[7:1] == DEV_ADDR) begin
                            sda_oe <= 1'b1;
                            is_rd  <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (is_rd) begin
                            tx     <= cnt_byte;
                            sda_oe <= ~cnt_byte[7];
                            rd_ptr <= '0;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            pos    <= '0;
                            state  <= ST_WR;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (pos != POS_MAX) pos <= pos + 1'b1;
                        state  <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev.scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) host_ack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (host_ack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            if (rd_ptr != POS_MAX) rd_ptr <= rd_ptr + 1'b1;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    AST_OE_IN_DRIVE_SLOT: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD}))
        else $error("sda driven outside ack/read slot"); // R11

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && !sda_oe && bitcnt == 4'd0))
        else $error("start did not restart address phase"); // R10

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (state == ST_IDLE && !sda_oe))
        else $error("stop did not return to idle"); // R11

    AST_WR_NEEDS_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> !is_rd)
        else $error("register write during read transaction"); // R1

endmodule

// File: rtl/blkwr_regfile.sv
module blkwr_regfile
    import blkwr_pkg::*;
#(
    parameter int         NREG      = 21,
    parameter logic [2:0] VENDOR_ID = 3'b001,
    parameter logic [4:0] REV_ID    = 5'h00,
    parameter byte_t      CNT_RESET = 8'h08
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  logic                  txn_end,
    input  logic [POS_W-1:0]      rd_ptr,
    output byte_t                 rd_data,
    output byte_t                 cnt_byte,
    output logic [NREG-1:0][7:0]  bank
);

    localparam byte_t ID_BYTE = {VENDOR_ID, REV_ID};

    logic [NREG-1:0][7:0]   mem;
    logic [NPAIRS-1:0]      pend_v;
    logic [NPAIRS-1:0][7:0] pend_data;
    logic [NPAIRS-1:0]      commit;

    generate
        for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
            localparam int LO = pair_base(p);
            logic  pv;
            byte_t pd;

            always_ff @(posedge clk) begin
                if (rst || txn_end) begin
                    pv <= 1'b0;
                end else if (wr.en && wr.idx == POS_W'(LO)) begin
                    pv <= 1'b1;
                    pd <= wr.data;
                end else if (wr.en && wr.idx == POS_W'(LO + 1)) begin
                    pv <= 1'b0;
                end
            end

            assign pend_v[p]    = pv;
            assign pend_data[p] = pd;
            assign commit[p]    = wr.en && (wr.idx == POS_W'(LO + 1)) && pv;

            AST_HALF_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
                (wr.en && wr.idx == POS_W'(LO + 1) && !pv) |=> $stable({mem[LO], mem[LO + 1]}))
                else $error("lone pair byte changed a register"); // R7

            AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
                txn_end |=> !pv)
                else $error("pending pair byte survived transaction end"); // R7
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reset_val(i, CNT_RESET, ID_BYTE);
        end else begin
            for (int i = 0; i < NREG; i++)
                if (wr.en && wr.idx == POS_W'(i) && plain_wr(i)) mem[i] <= wr.data;
            for (int p = 0; p < NPAIRS; p++)
                if (commit[p]) begin
                    mem[pair_base(p)]     <= pend_data[p];
                    mem[pair_base(p) + 1] <= wr.data;
                end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_ptr == POS_W'(i)) rd_data = mem[i];
    end

    assign cnt_byte = mem[CNT_REG];
    assign bank     = mem;

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx >= POS_W'(NREG)) |=> $stable(mem))
        else $error("write beyond bank changed a register"); // R4

    AST_ID_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == POS_W'(ID_REG)) |=> $stable(mem[ID_REG]))
        else $error("identity register was overwritten"); // R8

endmodule

// File: rtl/blkwr_reg_slave.sv
module blkwr_reg_slave
    import blkwr_pkg::*;
#(
    parameter int         NREG        = 21,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] VENDOR_ID   = 3'b001,
    parameter logic [4:0] REV_ID      = 5'h00,
    parameter logic [7:0] CNT_RESET   = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] bank_o
);

    line_ev_t             ev;
    wr_req_t              wr;
    logic                 txn_end;
    logic [POS_W-1:0]     rd_ptr;
    byte_t                rd_data;
    byte_t                cnt_byte;
    logic [NREG-1:0][7:0] bank;

    blkwr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    blkwr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cnt_byte (cnt_byte),
        .rd_data  (rd_data),
        .rd_ptr   (rd_ptr),
        .wr       (wr),
        .txn_end  (txn_end),
        .sda_oe   (sda_oe)
    );

    blkwr_regfile #(
        .NREG      (NREG),
        .VENDOR_ID (VENDOR_ID),
        .REV_ID    (REV_ID),
        .CNT_RESET (CNT_RESET)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .txn_end  (txn_end),
        .rd_ptr   (rd_ptr),
        .rd_data  (rd_data),
        .cnt_byte (cnt_byte),
        .bank     (bank)
    );

    assign bank_o = bank;

endmodule

// File: tb/blkwr_reg_slave_bench.sv
module blkwr_reg_slave_bench;

    localparam int NREG = 21;
    localparam int Q    = 10;   // clk cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] bank_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_mem [NREG];

    always #2 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    blkwr_reg_slave #(.REV_ID(5'h0B)) u_blkwr_reg_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .bank_o (bank_o)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_low = 1'b1; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_low = 1'b0; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b;   hold(Q);
        m_scl = 1'b1; hold(2 * Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        for (int b = 7; b >= 0; b--) send_bit(d[b]);
        m_low = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        acked = (sda_line == 1'b0);
        hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int b = 7; b >= 0; b--) begin
            m_low = 1'b0; hold(Q);
            m_scl = 1'b1; hold(Q);
            d[b] = sda_line;
            hold(Q);
            m_scl = 1'b0; hold(Q);
        end
        m_low = give_ack; hold(Q);
        m_scl = 1'b1; hold(2 * Q);
        m_scl = 1'b0; hold(Q);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] bank_byte(input int i);
        return bank_o[i*8 +: 8];
    endfunction

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++) check(tag, 32'(bank_byte(i)), 32'(exp_mem[i]));
    endtask

    // expected effect of n completed data bytes, from R3/R4/R7/R8/R9
    task automatic model_write(input int n, input logic [7:0] d [32]);
        for (int i = 0; i < n && i < NREG; i++) begin
            if (i == 7 || i == 6 || i == 19 || i == 20) continue;
            if (i == 12 || i == 14) continue;
            if (i == 11 || i == 13) begin
                if (n > i + 1) begin
                    exp_mem[i]     = d[i];
                    exp_mem[i + 1] = d[i + 1];
                end
                continue;
            end
            exp_mem[i] = d[i];
        end
    endtask

    task automatic write_txn(input int n, input logic [7:0] d [32], input string tag);
        logic a;
        bus_start();
        send_byte(8'hD2, a); check({tag, " R1 write address ack"}, 32'(a), 32'd1);
        send_byte(8'hC3, a); check({tag, " R2 command ack"}, 32'(a), 32'd1);
        send_byte(8'h3C, a); check({tag, " R2 count ack"}, 32'(a), 32'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            if (i < NREG) check({tag, " R3 data ack"}, 32'(a), 32'd1);
            else          check({tag, " R4 overflow ack"}, 32'(a), 32'd1);
        end
        bus_stop();
        hold(Q);
        model_write(n, d);
    endtask

    task automatic read_check(input int n, input string tag);
        logic a;
        logic [7:0] q;
        bus_start();
        send_byte(8'hD3, a); check({tag, " R1 read address ack"}, 32'(a), 32'd1);
        for (int k = 0; k <= n; k++) begin
            recv_byte(k != n, q);
            if (k == 0) check({tag, " R5 count byte"}, 32'(q), 32'(exp_mem[8]));
            else        check({tag, " R5 register byte"}, 32'(q), 32'(exp_mem[k - 1]));
        end
        hold(Q);
        check({tag, " R5 sda released after nack"}, 32'(sda_oe), 32'd0);
        bus_stop();
        hold(Q);
        check({tag, " R11 idle after stop"}, 32'(sda_oe), 32'd0);
    endtask

    function automatic void fill(output logic [7:0] d [32], input logic [7:0] seed);
        for (int i = 0; i < 32; i++) d[i] = seed ^ 8'(i * 8'h1D);
    endfunction

    task automatic t_reset();
        exp_mem[0] = 8'h00;
        for (int i = 1; i <= 5; i++) exp_mem[i] = 8'hFF;
        for (int i = 6; i < NREG; i++) exp_mem[i] = 8'h00;
        exp_mem[7] = 8'h2B;   // R8: vendor 001, revision 0x0B
        exp_mem[8] = 8'h08;   // R6
        check_bank("R6 reset bank");
        check("R11 no drive after reset", 32'(sda_oe), 32'd0);
        read_check(8, "R6 default length read");
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hA4, a);
        check("R1 foreign address nack", 32'(a), 32'd0);
        send_byte(8'h00, a);
        check("R1 ignored after nack", 32'(a), 32'd0);
        bus_stop();
        hold(Q);
        check_bank("R1 bank untouched");
    endtask

    task automatic t_sequential();
        logic [7:0] d [32];
        fill(d, 8'h40);
        d[8] = 8'h0A;
        write_txn(9, d, "R3 nine bytes");
        check("R2 reg0 holds first data byte", 32'(bank_byte(0)), 32'(d[0]));
        check_bank("R3 bank after write");
        fill(d, 8'h99);
        write_txn(3, d, "R3 partial");
        check_bank("R3 stop after third byte");
        read_check(10, "R5 length 10 read");
    endtask

    task automatic t_pairs();
        logic [7:0] d [32];
        logic [7:0] keep11;
        logic [7:0] keep13;
        fill(d, 8'h17);
        d[8] = 8'h0F;
        keep11 = exp_mem[11];
        write_txn(12, d, "R7 lone 11");
        check("R7 reg11 unchanged", 32'(bank_byte(11)), 32'(keep11));
        fill(d, 8'h25);
        d[8] = 8'h0F;
        write_txn(13, d, "R7 pair 11/12");
        check("R7 reg11 committed", 32'(bank_byte(11)), 32'(d[11]));
        check("R7 reg12 committed", 32'(bank_byte(12)), 32'(d[12]));
        fill(d, 8'h63);
        d[8] = 8'h0F;
        keep13 = exp_mem[13];
        write_txn(14, d, "R7 lone 13");
        check("R7 reg13 unchanged", 32'(bank_byte(13)), 32'(keep13));
        fill(d, 8'h5A);
        d[8] = 8'h0F;
        write_txn(15, d, "R7 pair 13/14");
        check("R7 reg14 committed", 32'(bank_byte(14)), 32'(d[14]));
        check_bank("R7 bank after pairs");
    endtask

    task automatic t_inert_overflow();
        logic [7:0] d [32];
        fill(d, 8'hC1);
        d[8]  = 8'd21;
        d[7]  = 8'hE4;
        d[6]  = 8'h77;
        d[19] = 8'h5E;
        d[20] = 8'hA1;
        write_txn(25, d, "R4 overflow write");
        check("R8 reg7 read-only", 32'(bank_byte(7)), 32'h2B);
        check("R9 reg6 no effect", 32'(bank_byte(6)), 32'h00);
        check("R9 reg19 no effect", 32'(bank_byte(19)), 32'h00);
        check("R9 reg20 no effect", 32'(bank_byte(20)), 32'h00);
        check_bank("R4 bank after overflow");
        read_check(21, "R9 full bank read");
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] q;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h3E, a);
        check("R10 first byte ack", 32'(a), 32'd1);
        for (int b = 0; b < 4; b++) send_bit(1'b0);
        bus_start();
        exp_mem[0] = 8'h3E;
        send_byte(8'hD3, a);
        check("R10 new address phase ack", 32'(a), 32'd1);
        recv_byte(1'b1, q);
        check("R10 count byte after restart", 32'(q), 32'(exp_mem[8]));
        recv_byte(1'b1, q);
        check("R10 completed byte kept", 32'(q), 32'h3E);
        recv_byte(1'b0, q);
        check("R10 aborted byte not stored", 32'(q), 32'(exp_mem[1]));
        bus_stop();
        hold(Q);
        check_bank("R10 bank after restart");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        hold(5);
        rst = 1'b0;
        hold(5);
        t_reset();
        t_bad_addr();
        t_sequential();
        t_pairs();
        t_inert_overflow();
        t_restart();
        finish_run();
    end

endmodule